// File: doc/BRIEF.md
# Directory Home Node Controller

This block is the home side of a directory coherence scheme for cores joined by a point-to-point network. For every line it owns, it keeps a small record: whether the line is uncached, shared or modified, which core owns a dirty copy, and a bit-vector of cores with clean copies. Cores send read, write and writeback requests to it. Cores also send acknowledgements: invalidation acks, recall data and forward-done notices. All of these arrive on a single valid/ready request port.

The controller answers on a response port, one message per cycle, each message addressed to one core. It sends read data, write grants and writeback acks to requesters. It sends invalidations only to recorded sharers, and it sends recalls or forwarded reads only to the recorded owner. A read that finds the line dirty elsewhere is resolved by one of two methods, chosen per request by an input:
- A four-hop recall: home pulls the line back from the owner and then replies to the requester.
- A three-hop forward: the owner answers the requester directly and then tells home.

If an owner writes the line back while its read is in flight, home takes the writeback as the owner's answer to that read.

The controller has one transaction slot. While a line's transaction is open, new reads and writes wait with `req_ready` low. Acknowledgements are always taken. Responses leave one cycle after the request or event that causes them.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset no message is sent (`rsp_valid` low), `req_ready` is high, and every line is uncached.
- R2: A READ (req_kind 0) to a line that is uncached, shared, or modified by the requester itself is answered with READ_DATA (rsp_kind 1) to the requester. The requester is then a sharer of a line that was not modified.
- R3: With `three_hop` low, a READ to a line modified at another core sends RECALL (rsp_kind 5) to the owner. When RECALL_DATA (req_kind 4) comes back from that owner, home sends READ_DATA to the requester. The line becomes shared by the owner and the requester.
- R4: With `three_hop` high, the same READ sends FWD_READ (rsp_kind 6) to the owner. A FWD_DONE (req_kind 5) from the owner closes the transaction with no message from home, and the line becomes shared by the owner and the requester.
- R5: A WRITE (req_kind 1) to a shared line sends INVAL (rsp_kind 4) to each sharer other than the writer. The INVALs go out one per cycle in ascending core index. WRITE_GRANT (rsp_kind 2) follows only after that many INV_ACKs (req_kind 3) for the line have arrived. The writer then becomes owner.
- R6: A WRITE to an uncached line, to a line where the writer is the only sharer, or to a line the writer already owns is granted at once with no INVAL. A WRITE to a line modified elsewhere sends INVAL to the owner and waits for one INV_ACK.
- R7: Messages go only to the requester, the recorded owner or the recorded sharers. No other core ever receives an INVAL, RECALL or FWD_READ.
- R8: A WBACK (req_kind 2) from the owner of a modified line, with no transaction open, is answered with WBACK_ACK (rsp_kind 3), and the line becomes uncached. A WBACK from a core that is not the owner is ignored and sends nothing.
- R9: A WBACK from the owner while its RECALL or FWD_READ is pending is taken as the owner's answer. Home sends READ_DATA to the requester and no WBACK_ACK, and the line becomes shared by the requester alone.
- R10: While a transaction is open, READ and WRITE requests are held with `req_ready` low. Acknowledgement kinds (3, 4, 5) are always accepted, and an acknowledgement that matches no open transaction is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| three_hop | input | 1 | Sampled with a READ: 1 forwards to the owner, 0 recalls through home |
| req_valid | input | 1 | Request or acknowledgement present |
| req_ready | output | 1 | Request is taken on this edge |
| req_kind | input | 3 | 0 READ, 1 WRITE, 2 WBACK, 3 INV_ACK, 4 RECALL_DATA, 5 FWD_DONE |
| req_src | input | CW | Sending core |
| req_line | input | LW | Line index |
| rsp_valid | output | 1 | Message present (one cycle) |
| rsp_kind | output | 3 | 1 READ_DATA, 2 WRITE_GRANT, 3 WBACK_ACK, 4 INVAL, 5 RECALL, 6 FWD_READ |
| rsp_dst | output | CW | Destination core |
| rsp_line | output | LW | Line index |

## Verification
The main sweep covers every sharer set of four cores against every writing core. The readers in the set build up the sharer vector, and then the write must produce exactly the INVALs for the set minus the writer, in ascending order, followed by one grant. An empty remainder separates the immediate-grant path from the counted path, and a writer inside the set separates it from one outside the set. Directed runs cover a dirty read under recall and under forward. A follow-up write reveals the sharer set each one leaves behind. Further runs cover the writeback race, a writeback from a core that is not the owner, a stray acknowledgement, and requests that arrive while a transaction is open.

// File: rtl/dir_home_pkg.sv
package dir_home_pkg;

    typedef enum logic [1:0] {
        LN_UNCACHED = 2'd0,
        LN_SHARED   = 2'd1,
        LN_MODIFIED = 2'd2
    } line_state_e;

    typedef enum logic [2:0] {
        RQ_READ        = 3'd0,
        RQ_WRITE       = 3'd1,
        RQ_WBACK       = 3'd2,
        RQ_INV_ACK     = 3'd3,
        RQ_RECALL_DATA = 3'd4,
        RQ_FWD_DONE    = 3'd5
    } req_kind_e;

    typedef enum logic [2:0] {
        MS_NONE        = 3'd0,
        MS_READ_DATA   = 3'd1,
        MS_WRITE_GRANT = 3'd2,
        MS_WBACK_ACK   = 3'd3,
        MS_INVAL       = 3'd4,
        MS_RECALL      = 3'd5,
        MS_FWD_READ    = 3'd6
    } msg_kind_e;

    typedef enum logic [1:0] {
        HC_IDLE  = 2'd0,
        HC_INVAL = 2'd1,
        HC_OWNER = 2'd2
    } home_phase_e;

    localparam int unsigned MASK_MAX = 32;

    function automatic int unsigned ones_in(input logic [MASK_MAX-1:0] v);
        int unsigned n = 0;
        for (int i = 0; i < MASK_MAX; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic logic is_ack(input req_kind_e k);
        return (k == RQ_INV_ACK) || (k == RQ_RECALL_DATA) || (k == RQ_FWD_DONE);
    endfunction

endpackage

// File: rtl/dir_table.sv
module dir_table
    import dir_home_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LW-1:0]      rd_idx,
    output line_state_e        rd_st,
    output logic [CW-1:0]      rd_own,
    output logic [N_CORES-1:0] rd_shr,
    input  logic               wr_en,
    input  logic [LW-1:0]      wr_idx,
    input  line_state_e        wr_st,
    input  logic [CW-1:0]      wr_own,
    input  logic [N_CORES-1:0] wr_shr
);

    line_state_e        st_q  [N_LINES];
    logic [CW-1:0]      own_q [N_LINES];
    logic [N_CORES-1:0] shr_q [N_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LINES; i++) begin
                st_q[i]  <= LN_UNCACHED;
                own_q[i] <= '0;
                shr_q[i] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx]  <= wr_st;
            own_q[wr_idx] <= wr_own;
            shr_q[wr_idx] <= wr_shr;
        end
    end

    assign rd_st  = st_q[rd_idx];
    assign rd_own = own_q[rd_idx];
    assign rd_shr = shr_q[rd_idx];

    // R5
    mod_no_sharers_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_st == LN_MODIFIED) |-> (wr_shr == '0));

    // R2
    shared_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_st == LN_SHARED) |-> (wr_shr != '0));

endmodule

// File: rtl/dir_inv_tracker.sv
module dir_inv_tracker #(
    parameter int unsigned N_CORES = 4,
    localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int unsigned NW = $clog2(N_CORES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [N_CORES-1:0] load_mask,
    input  logic [NW-1:0]      load_cnt,
    input  logic               issue,
    input  logic               ack,
    output logic [CW-1:0]      tgt,
    output logic               mask_any,
    output logic               cnt_zero
);

    logic [N_CORES-1:0] mask_q;
    logic [NW-1:0]      cnt_q;

    always_comb begin
        tgt = '0;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (mask_q[i]) tgt = CW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            cnt_q  <= load_cnt;
        end else begin
            if (issue) mask_q[tgt] <= 1'b0;
            if (ack && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mask_any = (mask_q != '0);
    assign cnt_zero = (cnt_q == '0);

    // R5
    ack_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mask_any |-> (32'(cnt_q) >= 32'($countones(mask_q))));

    // R5
    load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_cnt != '0 && load_mask != '0));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_home_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned N_LINES = 8,
    localparam int unsigned CW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int unsigned LW = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int unsigned NW = $clog2(N_CORES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          three_hop,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_kind,
    input  logic [CW-1:0] req_src,
    input  logic [LW-1:0] req_line,
    output logic          rsp_valid,
    output logic [2:0]    rsp_kind,
    output logic [CW-1:0] rsp_dst,
    output logic [LW-1:0] rsp_line
);

    home_phase_e phase_q, phase_d;
    logic [LW-1:0] line_q, line_d;
    logic [CW-1:0] req_q, req_d, own_q, own_d;
    logic          fwd_q, fwd_d;

    line_state_e        rd_st, wr_st;
    logic [CW-1:0]      rd_own, wr_own;
    logic [N_CORES-1:0] rd_shr, wr_shr;
    logic               wr_en;

    logic               t_load, t_issue, t_ack, mask_any, cnt_zero;
    logic [N_CORES-1:0] t_mask;
    logic [NW-1:0]      t_cnt;
    logic [CW-1:0]      tgt;

    logic          msg_v;
    msg_kind_e     msg_k;
    logic [CW-1:0] msg_dst;
    logic [LW-1:0] msg_line;

    req_kind_e          kind;
    logic               take;
    logic [N_CORES-1:0] src_bit, others;

    assign kind    = req_kind_e'(req_kind);
    assign src_bit = N_CORES'(1) << req_src;
    assign others  = rd_shr & ~src_bit;
    assign take    = req_valid && req_ready;

    dir_table #(.N_CORES(N_CORES), .N_LINES(N_LINES)) u_table (
        .clk(clk), .rst(rst),
        .rd_idx(req_line), .rd_st(rd_st), .rd_own(rd_own), .rd_shr(rd_shr),
        .wr_en(wr_en), .wr_idx(phase_q == HC_IDLE ? req_line : line_q),
        .wr_st(wr_st), .wr_own(wr_own), .wr_shr(wr_shr)
    );

    dir_inv_tracker #(.N_CORES(N_CORES)) u_track (
        .clk(clk), .rst(rst),
        .load(t_load), .load_mask(t_mask), .load_cnt(t_cnt),
        .issue(t_issue), .ack(t_ack),
        .tgt(tgt), .mask_any(mask_any), .cnt_zero(cnt_zero)
    );

    always_comb begin
        unique case (phase_q)
            HC_IDLE:  req_ready = 1'b1;
            HC_INVAL: req_ready = is_ack(kind);
            HC_OWNER: req_ready = is_ack(kind) ||
                                  (kind == RQ_WBACK && req_src == own_q && req_line == line_q);
            default:  req_ready = 1'b0;
        endcase
    end

    always_comb begin
        phase_d = phase_q; line_d = line_q; req_d = req_q; own_d = own_q; fwd_d = fwd_q;
        wr_en = 1'b0; wr_st = LN_UNCACHED; wr_own = '0; wr_shr = '0;
        t_load = 1'b0; t_mask = '0; t_cnt = '0; t_issue = 1'b0; t_ack = 1'b0;
        msg_v = 1'b0; msg_k = MS_NONE; msg_dst = '0; msg_line = req_line;
        unique case (phase_q)
            HC_IDLE: if (take) begin
                line_d = req_line;
                req_d  = req_src;
                case (kind)
                    RQ_READ: begin
                        if (rd_st == LN_MODIFIED && rd_own != req_src) begin
                            own_d   = rd_own;
                            fwd_d   = three_hop;
                            msg_v   = 1'b1;
                            msg_k   = three_hop ? MS_FWD_READ : MS_RECALL;
                            msg_dst = rd_own;
                            phase_d = HC_OWNER;
                        end else begin
                            msg_v   = 1'b1;
                            msg_k   = MS_READ_DATA;
                            msg_dst = req_src;
                            if (rd_st != LN_MODIFIED) begin
                                wr_en  = 1'b1;
                                wr_st  = LN_SHARED;
                                wr_shr = rd_shr | src_bit;
                            end
                        end
                    end
                    RQ_WRITE: begin
                        if (rd_st == LN_UNCACHED ||
                            (rd_st == LN_MODIFIED && rd_own == req_src) ||
                            (rd_st == LN_SHARED && others == '0)) begin
                            msg_v   = 1'b1;
                            msg_k   = MS_WRITE_GRANT;
                            msg_dst = req_src;
                            wr_en   = 1'b1;
                            wr_st   = LN_MODIFIED;
                            wr_own  = req_src;
                        end else begin
                            t_load  = 1'b1;
                            if (rd_st == LN_MODIFIED) begin
                                t_mask = N_CORES'(1) << rd_own;
                                t_cnt  = NW'(1);
                            end else begin
                                t_mask = others;
                                t_cnt  = NW'(ones_in(MASK_MAX'(others)));
                            end
                            phase_d = HC_INVAL;
                        end
                    end
                    RQ_WBACK: begin
                        if (rd_st == LN_MODIFIED && rd_own == req_src) begin
                            wr_en   = 1'b1;
                            wr_st   = LN_UNCACHED;
                            msg_v   = 1'b1;
                            msg_k   = MS_WBACK_ACK;
                            msg_dst = req_src;
                        end
                    end
                    default: ;
                endcase
            end
            HC_INVAL: begin
                t_ack    = take && kind == RQ_INV_ACK && req_line == line_q;
                msg_line = line_q;
                if (mask_any) begin
                    msg_v   = 1'b1;
                    msg_k   = MS_INVAL;
                    msg_dst = tgt;
                    t_issue = 1'b1;
                end else if (cnt_zero) begin
                    msg_v   = 1'b1;
                    msg_k   = MS_WRITE_GRANT;
                    msg_dst = req_q;
                    wr_en   = 1'b1;
                    wr_st   = LN_MODIFIED;
                    wr_own  = req_q;
                    phase_d = HC_IDLE;
                end
            end
            HC_OWNER: begin
                msg_line = line_q;
                if (take && req_line == line_q && req_src == own_q) begin
                    if (kind == (fwd_q ? RQ_FWD_DONE : RQ_RECALL_DATA)) begin
                        wr_en   = 1'b1;
                        wr_st   = LN_SHARED;
                        wr_shr  = (N_CORES'(1) << own_q) | (N_CORES'(1) << req_q);
                        msg_v   = !fwd_q;
                        msg_k   = MS_READ_DATA;
                        msg_dst = req_q;
                        phase_d = HC_IDLE;
                    end else if (kind == RQ_WBACK) begin
                        wr_en   = 1'b1;
                        wr_st   = LN_SHARED;
                        wr_shr  = N_CORES'(1) << req_q;
                        msg_v   = 1'b1;
                        msg_k   = MS_READ_DATA;
                        msg_dst = req_q;
                        phase_d = HC_IDLE;
                    end
                end
            end
            default: phase_d = HC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= HC_IDLE;
            line_q    <= '0;
            req_q     <= '0;
            own_q     <= '0;
            fwd_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_kind  <= 3'(MS_NONE);
            rsp_dst   <= '0;
            rsp_line  <= '0;
        end else begin
            phase_q   <= phase_d;
            line_q    <= line_d;
            req_q     <= req_d;
            own_q     <= own_d;
            fwd_q     <= fwd_d;
            rsp_valid <= msg_v;
            rsp_kind  <= 3'(msg_k);
            rsp_dst   <= msg_dst;
            rsp_line  <= msg_line;
        end
    end

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (rst)
        (take && phase_q != HC_IDLE) |-> (kind != RQ_READ && kind != RQ_WRITE));

    // R5
    grant_after_acks_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 3'(MS_WRITE_GRANT) && $past(phase_q) == HC_INVAL)
        |-> $past(cnt_zero));

    // R7
    inval_target_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_kind == 3'(MS_INVAL)) |-> (rsp_dst != req_q && phase_q == HC_INVAL));

    // R7
    owner_target_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_kind == 3'(MS_FWD_READ) || rsp_kind == 3'(MS_RECALL)))
        |-> (rsp_dst == own_q && phase_q == HC_OWNER));

endmodule

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
    import dir_home_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       three_hop = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_kind = '0;
    logic [1:0] req_src = '0;
    logic [2:0] req_line = '0;
    logic       rsp_valid;
    logic [2:0] rsp_kind;
    logic [1:0] rsp_dst;
    logic [2:0] rsp_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int log_n = 0;
    int rd_i = 0;
    int lk [0:2047];
    int ld [0:2047];
    int ll [0:2047];

    always #2.5 clk = ~clk;

    dir_home_ctrl u_dir_home_ctrl (
        .clk(clk), .rst(rst), .three_hop(three_hop),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst), .rsp_line(rsp_line)
    );

    always @(posedge clk) begin
        #1;
        if (rsp_valid && log_n < 2048) begin
            lk[log_n] = int'(rsp_kind);
            ld[log_n] = int'(rsp_dst);
            ll[log_n] = int'(rsp_line);
            log_n++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog: run did not finish, cycles %0d expected below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic send(input logic [2:0] k, input int s, input int l);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = 2'(s); req_line = 3'(l);
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic probe_stall(input logic [2:0] k, input int s, input int l, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = 2'(s); req_line = 3'(l);
        #1;
        checks++;
        if (req_ready !== 1'b0) begin
            errors++;
            $display("FAIL %s: req_ready %0b expected 0", tag, req_ready);
        end
        req_valid = 1'b0;
    endtask

    task automatic expect_msg(input logic [2:0] k, input int d, input int l, input string tag);
        int waited = 0;
        while (log_n <= rd_i && waited < 20) begin @(negedge clk); waited++; end
        checks++;
        if (log_n <= rd_i) begin
            errors++;
            $display("FAIL %s: no message, expected kind %0d dst %0d line %0d", tag, k, d, l);
        end else begin
            if (lk[rd_i] != int'(k) || ld[rd_i] != d || ll[rd_i] != l) begin
                errors++;
                $display("FAIL %s: got kind %0d dst %0d line %0d, expected kind %0d dst %0d line %0d",
                         tag, lk[rd_i], ld[rd_i], ll[rd_i], k, d, l);
            end
            rd_i++;
        end
    endtask

    task automatic expect_quiet(input string tag);
        repeat (6) @(negedge clk);
        checks++;
        if (log_n != rd_i) begin
            errors++;
            $display("FAIL %s: got kind %0d dst %0d, expected no message", tag, lk[rd_i], ld[rd_i]);
            rd_i = log_n;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R1: rsp_valid %0b req_ready %0b, expected 0 and 1", rsp_valid, req_ready);
        end
        expect_quiet("R1 idle after reset");

        // R2 R5 R6 R7 R8 sweep: every sharer set against every writer
        for (int m = 0; m < 16; m++) begin
            for (int w = 0; w < 4; w++) begin
                int ln = (m * 4 + w) % 8;
                int nexp = 0;
                for (int c = 0; c < 4; c++) begin
                    if (m[c]) begin
                        send(RQ_READ, c, ln);
                        expect_msg(MS_READ_DATA, c, ln, "R2 read data");
                    end
                end
                send(RQ_WRITE, w, ln);
                for (int c = 0; c < 4; c++) begin
                    if (m[c] && c != w) begin
                        expect_msg(MS_INVAL, c, ln, "R5 R7 inval to sharer");
                        nexp++;
                    end
                end
                for (int c = 0; c < 4; c++) begin
                    if (m[c] && c != w) send(RQ_INV_ACK, c, ln);
                end
                expect_msg(MS_WRITE_GRANT, w, ln, nexp == 0 ? "R6 direct grant" : "R5 grant after acks");
                send(RQ_WBACK, w, ln);
                expect_msg(MS_WBACK_ACK, w, ln, "R8 plain writeback");
            end
        end

        // R3 four-hop recall
        three_hop = 1'b0;
        send(RQ_WRITE, 0, 1);
        expect_msg(MS_WRITE_GRANT, 0, 1, "R6 grant uncached");
        send(RQ_READ, 2, 1);
        expect_msg(MS_RECALL, 0, 1, "R3 recall to owner");
        probe_stall(RQ_READ, 3, 1, "R10 read held during recall");
        send(RQ_RECALL_DATA, 0, 1);
        expect_msg(MS_READ_DATA, 2, 1, "R3 data after recall");
        send(RQ_WRITE, 3, 1);
        expect_msg(MS_INVAL, 0, 1, "R3 owner kept as sharer");
        expect_msg(MS_INVAL, 2, 1, "R3 requester is sharer");
        probe_stall(RQ_WRITE, 1, 5, "R10 write held during invalidation");
        send(RQ_INV_ACK, 0, 1);
        expect_quiet("R5 no grant after first of two acks");
        send(RQ_INV_ACK, 2, 1);
        expect_msg(MS_WRITE_GRANT, 3, 1, "R5 grant after last ack");

        // R4 three-hop forward
        three_hop = 1'b1;
        send(RQ_WRITE, 1, 2);
        expect_msg(MS_WRITE_GRANT, 1, 2, "R6 grant uncached");
        send(RQ_READ, 3, 2);
        expect_msg(MS_FWD_READ, 1, 2, "R4 forward to owner");
        send(RQ_FWD_DONE, 1, 2);
        expect_quiet("R4 no reply from home");
        send(RQ_WRITE, 0, 2);
        expect_msg(MS_INVAL, 1, 2, "R4 owner kept as sharer");
        expect_msg(MS_INVAL, 3, 2, "R4 requester is sharer");
        send(RQ_INV_ACK, 1, 2);
        send(RQ_INV_ACK, 3, 2);
        expect_msg(MS_WRITE_GRANT, 0, 2, "R5 grant");

        // R9 writeback racing a forwarded read
        send(RQ_WRITE, 2, 3);
        expect_msg(MS_WRITE_GRANT, 2, 3, "R6 grant uncached");
        send(RQ_READ, 0, 3);
        expect_msg(MS_FWD_READ, 2, 3, "R9 forward issued");
        send(RQ_WBACK, 2, 3);
        expect_msg(MS_READ_DATA, 0, 3, "R9 writeback serves read");
        expect_quiet("R9 no writeback ack");
        send(RQ_WRITE, 1, 3);
        expect_msg(MS_INVAL, 0, 3, "R9 requester sole sharer");
        send(RQ_INV_ACK, 0, 3);
        expect_msg(MS_WRITE_GRANT, 1, 3, "R9 grant after single ack");

        // R6 write to a line modified elsewhere
        send(RQ_WRITE, 3, 3);
        expect_msg(MS_INVAL, 1, 3, "R6 inval to owner");
        send(RQ_INV_ACK, 1, 3);
        expect_msg(MS_WRITE_GRANT, 3, 3, "R6 grant after owner ack");

        // R8 writeback from a core that is not the owner
        send(RQ_WBACK, 1, 4);
        expect_quiet("R8 stray writeback ignored");
        send(RQ_WBACK, 0, 3);
        expect_quiet("R8 non-owner writeback ignored");
        send(RQ_WRITE, 2, 4);
        expect_msg(MS_WRITE_GRANT, 2, 4, "R8 line still uncached");

        // R10 acknowledgement with nothing open
        send(RQ_INV_ACK, 1, 6);
        expect_quiet("R10 stray ack ignored");
        send(RQ_WRITE, 2, 6);
        expect_msg(MS_WRITE_GRANT, 2, 6, "R10 line unaffected by stray ack");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule